// File: doc/BRIEF.md
# External Data Memory Address Router

This block sits beside a small 8051-style core and decides where each access to the external data space goes. An access targets either the on-chip data RAM or a 12-bit off-chip address bus. The target and the address depend on a 2-bit mapping mode and on which pointer form the access uses. In the narrow form, a page register supplies the high byte and an 8-bit index register supplies the low byte. In the wide form, a 16-bit data pointer supplies the whole address.

The off-chip bus has two drive enables: one for the low address byte and one for the upper nibble. In the split map without bank select, a narrow-form off-chip access leaves the upper nibble undriven, so that port latches can set those pins. Read data reaches the core one cycle after the read strobe. The data comes from the on-chip RAM or from the external data input, depending on the routing decision that was registered with the strobe.

Top module: `xdata_router`

## Requirements
- R1: In mode 2'b00 every access goes to the on-chip RAM. The RAM address is the effective address modulo ONCHIP_BYTES, so address 4096 lands on byte 0 with the default size. No external strobe or drive enable is asserted in this mode.
- R2: When `wide_form`=0 the effective address is {page_reg, index_reg}. When `wide_form`=1 the effective address is `dptr`.
- R3: In modes 2'b01 and 2'b10, an effective address below ONCHIP_BYTES goes on-chip and one at or above it goes off-chip. In mode 2'b11 every access goes off-chip.
- R4: In mode 2'b01, a narrow-form off-chip access drives ext_addr[7:0] from index_reg with `ext_lo_oe`=1. It keeps `ext_hi_oe`=0, and ext_addr[11:8] reads as 0.
- R5: In modes 2'b10 and 2'b11, a narrow-form off-chip access drives ext_addr[11:8] from page_reg[3:0] and ext_addr[7:0] from index_reg, with both enables at 1.
- R6: A wide-form off-chip access drives ext_addr[11:0] from dptr[11:0], with both enables at 1.
- R7: `ram_sel`/`ram_we` are asserted only for on-chip accesses, and `ext_rd`/`ext_wr` only for off-chip accesses. With no strobe, every select, strobe and enable is 0 and `ext_addr` is 0. Write data passes unchanged to `ram_wdata` and `ext_wdata`.
- R8: In the cycle after a read, `rd_data` equals `ram_rdata` if the read went on-chip, and `ext_rdata` if it went off-chip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| mode | input | 2 | Mapping mode (00 on-chip, 01 split flat, 10 split banked, 11 off-chip) |
| wide_form | input | 1 | 1 = 16-bit pointer form, 0 = page/index form |
| page_reg | input | 8 | High address byte for the narrow form |
| index_reg | input | 8 | Low address byte for the narrow form |
| dptr | input | 16 | Address for the wide form |
| rd_req | input | 1 | Read strobe |
| wr_req | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| ram_addr | output | 12 | On-chip RAM address |
| ram_sel | output | 1 | On-chip RAM select |
| ram_we | output | 1 | On-chip RAM write enable |
| ram_wdata | output | 8 | On-chip RAM write data |
| ram_rdata | input | 8 | On-chip RAM read data (one-cycle latency) |
| ext_addr | output | 12 | Off-chip address bus |
| ext_lo_oe | output | 1 | Drive enable for ext_addr[7:0] |
| ext_hi_oe | output | 1 | Drive enable for ext_addr[11:8] |
| ext_rd | output | 1 | Off-chip read strobe |
| ext_wr | output | 1 | Off-chip write strobe |
| ext_wdata | output | 8 | Off-chip write data |
| ext_rdata | input | 8 | Off-chip read data (valid the cycle after ext_rd) |
| rd_data | output | 8 | Read data to the core |

## Verification
A sequential fill past the top of the on-chip RAM in mode 00, followed by a read of byte 0, shows whether addresses wrap or leak off-chip. Narrow-form accesses with page values just below and at the boundary, repeated in each split mode, separate the flat map from the banked map through the upper-nibble enable. Wide-form pointers on both sides of the boundary exercise the full-bus drive. A long pseudo-random mix of modes, forms, reads, writes and idle cycles is compared each clock against a behavioural model that keeps its own copy of the on-chip contents.

// File: rtl/xdr_pkg.sv
package xdr_pkg;

   typedef enum logic [1:0] {
      XM_ONCHIP     = 2'b00,
      XM_SPLIT_FLAT = 2'b01,
      XM_SPLIT_BANK = 2'b10,
      XM_OFFCHIP    = 2'b11
   } xmode_e;

   typedef enum logic [1:0] {
      HI_NONE = 2'b00,
      HI_PAGE = 2'b01,
      HI_PTR  = 2'b10
   } hi_src_e;

endpackage

// File: rtl/xdr_ea_builder.sv
module xdr_ea_builder #(
   parameter int EA_W = 16
) (
   input  logic            wide_form,
   input  logic [7:0]      page_reg,
   input  logic [7:0]      index_reg,
   input  logic [EA_W-1:0] dptr,
   output logic [EA_W-1:0] ea
);
   localparam int PG_W = EA_W - 8;

   always_comb begin
      if (wide_form) ea = dptr;
      else           ea = {page_reg[PG_W-1:0], index_reg};
   end
endmodule

// File: rtl/xdr_decode.sv
module xdr_decode
   import xdr_pkg::*;
#(
   parameter int ONCHIP_BYTES = 4096,
   parameter int EA_W         = 16,
   localparam int RAM_AW      = $clog2(ONCHIP_BYTES)
) (
   input  xmode_e            mode,
   input  logic              wide_form,
   input  logic [EA_W-1:0]   ea,
   output logic              go_ext,
   output logic [RAM_AW-1:0] ram_addr,
   output hi_src_e           hi_src
);
   logic below;

   generate
      if (RAM_AW >= EA_W) begin : g_full_space
         assign below = 1'b1;
      end else begin : g_bounded
         assign below = (ea[EA_W-1:RAM_AW] == '0);
      end
   endgenerate

   // modulo a power-of-two size keeps the low bits
   assign ram_addr = ea[RAM_AW-1:0];

   always_comb begin
      unique case (mode)
         XM_ONCHIP:                    go_ext = 1'b0;
         XM_SPLIT_FLAT, XM_SPLIT_BANK: go_ext = !below;
         default:                      go_ext = 1'b1;
      endcase
   end

   always_comb begin
      if (!go_ext)                    hi_src = HI_NONE;
      else if (wide_form)             hi_src = HI_PTR;
      else if (mode == XM_SPLIT_FLAT) hi_src = HI_NONE;
      else                            hi_src = HI_PAGE;
   end
endmodule

// File: rtl/xdr_ext_drive.sv
module xdr_ext_drive
   import xdr_pkg::*;
#(
   parameter int EXT_AW = 12,
   parameter int EA_W   = 16,
   localparam int HI_W  = EXT_AW - 8
) (
   input  logic              active,
   input  hi_src_e           hi_src,
   input  logic [EA_W-1:0]   ea,
   input  logic [7:0]        page_reg,
   output logic [EXT_AW-1:0] ext_addr,
   output logic              lo_oe,
   output logic              hi_oe
);
   logic [HI_W-1:0] hi_val;

   always_comb begin
      unique case (hi_src)
         HI_PAGE: hi_val = page_reg[HI_W-1:0];
         HI_PTR:  hi_val = ea[EXT_AW-1:8];
         default: hi_val = '0;
      endcase
   end

   assign lo_oe    = active;
   assign hi_oe    = active && (hi_src != HI_NONE);
   assign ext_addr = active ? {hi_val, ea[7:0]} : '0;
endmodule

// File: rtl/xdr_rdmux.sv
module xdr_rdmux #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rd_req,
   input  logic          go_ext,
   input  logic [DW-1:0] ram_rdata,
   input  logic [DW-1:0] ext_rdata,
   output logic [DW-1:0] rd_data
);
   logic from_ext_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      from_ext_q <= 1'b0;
      else if (rd_req) from_ext_q <= go_ext;
   end

   assign rd_data = from_ext_q ? ext_rdata : ram_rdata;
endmodule

// File: rtl/xdata_router.sv
module xdata_router
   import xdr_pkg::*;
#(
   parameter int ONCHIP_BYTES = 4096,
   parameter int EXT_AW       = 12,
   parameter int DW           = 8,
   localparam int EA_W        = 16,
   localparam int RAM_AW      = $clog2(ONCHIP_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        mode,
   input  logic              wide_form,
   input  logic [7:0]        page_reg,
   input  logic [7:0]        index_reg,
   input  logic [EA_W-1:0]   dptr,
   input  logic              rd_req,
   input  logic              wr_req,
   input  logic [DW-1:0]     wr_data,
   output logic [RAM_AW-1:0] ram_addr,
   output logic              ram_sel,
   output logic              ram_we,
   output logic [DW-1:0]     ram_wdata,
   input  logic [DW-1:0]     ram_rdata,
   output logic [EXT_AW-1:0] ext_addr,
   output logic              ext_lo_oe,
   output logic              ext_hi_oe,
   output logic              ext_rd,
   output logic              ext_wr,
   output logic [DW-1:0]     ext_wdata,
   input  logic [DW-1:0]     ext_rdata,
   output logic [DW-1:0]     rd_data
);
   generate
      if ((ONCHIP_BYTES & (ONCHIP_BYTES - 1)) != 0 || ONCHIP_BYTES < 256 || ONCHIP_BYTES > 65536) begin : g_bad_size
         $error("ONCHIP_BYTES must be a power of two from 256 to 65536");
      end
      if (EXT_AW < 9 || EXT_AW > 16) begin : g_bad_ext
         $error("EXT_AW must be from 9 to 16");
      end
   endgenerate

   xmode_e          mode_e;
   logic [EA_W-1:0] ea;
   logic            go_ext;
   logic            access;
   hi_src_e         hi_src;

   assign mode_e = xmode_e'(mode);
   assign access = rd_req || wr_req;

   xdr_ea_builder #(.EA_W(EA_W)) u_ea (
      .wide_form (wide_form),
      .page_reg  (page_reg),
      .index_reg (index_reg),
      .dptr      (dptr),
      .ea        (ea)
   );

   xdr_decode #(.ONCHIP_BYTES(ONCHIP_BYTES), .EA_W(EA_W)) u_dec (
      .mode      (mode_e),
      .wide_form (wide_form),
      .ea        (ea),
      .go_ext    (go_ext),
      .ram_addr  (ram_addr),
      .hi_src    (hi_src)
   );

   xdr_ext_drive #(.EXT_AW(EXT_AW), .EA_W(EA_W)) u_ext (
      .active    (access && go_ext),
      .hi_src    (hi_src),
      .ea        (ea),
      .page_reg  (page_reg),
      .ext_addr  (ext_addr),
      .lo_oe     (ext_lo_oe),
      .hi_oe     (ext_hi_oe)
   );

   xdr_rdmux #(.DW(DW)) u_rd (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_req    (rd_req),
      .go_ext    (go_ext),
      .ram_rdata (ram_rdata),
      .ext_rdata (ext_rdata),
      .rd_data   (rd_data)
   );

   assign ram_sel   = access && !go_ext;
   assign ram_we    = wr_req && !go_ext;
   assign ext_rd    = rd_req && go_ext;
   assign ext_wr    = wr_req && go_ext;
   assign ram_wdata = wr_data;
   assign ext_wdata = wr_data;

   // R7
   excl_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(ram_sel && (ext_rd || ext_wr)));

   // R1
   onchip_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b00) |-> (!ext_rd && !ext_wr && !ext_lo_oe && !ext_hi_oe));

   // R4
   flat_hi_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b01 && !wide_form) |-> !ext_hi_oe);

   // R6
   hi_needs_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ext_hi_oe |-> ext_lo_oe);

   // R3
   offchip_never_ram_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b11) |-> !ram_sel);

   // R8
   rd_ext_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ext_rd |=> (rd_data == ext_rdata));
endmodule

// File: tb/xdata_router_bench.sv
module xdata_router_bench;
   localparam int SIZE = 4096;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  mode = 2'b00;
   logic        wide_form = 1'b0;
   logic [7:0]  page_reg = 8'h00, index_reg = 8'h00;
   logic [15:0] dptr = 16'h0000;
   logic        rd_req = 1'b0, wr_req = 1'b0;
   logic [7:0]  wr_data = 8'h00;
   logic [11:0] ram_addr, ext_addr;
   logic        ram_sel, ram_we, ext_lo_oe, ext_hi_oe, ext_rd, ext_wr;
   logic [7:0]  ram_wdata, ext_wdata, rd_data;
   logic [7:0]  ram_rdata = 8'h00, ext_rdata = 8'h00;

   int total = 0;
   int bad = 0;

   always #10 clk = ~clk;

   xdata_router u_xdata_router (
      .clk(clk), .rst_n(rst_n), .mode(mode), .wide_form(wide_form),
      .page_reg(page_reg), .index_reg(index_reg), .dptr(dptr),
      .rd_req(rd_req), .wr_req(wr_req), .wr_data(wr_data),
      .ram_addr(ram_addr), .ram_sel(ram_sel), .ram_we(ram_we),
      .ram_wdata(ram_wdata), .ram_rdata(ram_rdata),
      .ext_addr(ext_addr), .ext_lo_oe(ext_lo_oe), .ext_hi_oe(ext_hi_oe),
      .ext_rd(ext_rd), .ext_wr(ext_wr), .ext_wdata(ext_wdata),
      .ext_rdata(ext_rdata), .rd_data(rd_data)
   );

   // peripheral models: on-chip RAM and an off-chip device
   logic [7:0] ram_mem [int];
   function automatic logic [7:0] ext_pattern(input logic [11:0] a);
      return a[7:0] ^ 8'hA5 ^ {a[11:8], 4'h0};
   endfunction

   always @(posedge clk) begin
      if (ram_sel) begin
         if (ram_we) ram_mem[int'(ram_addr)] = ram_wdata;
         else ram_rdata <= ram_mem.exists(int'(ram_addr)) ? ram_mem[int'(ram_addr)] : 8'h00;
      end
      if (ext_rd) ext_rdata <= ext_pattern(ext_addr);
   end

   task automatic chk(input string tag, input int act, input int exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
      end
   endtask

   // reference model, compared on every falling edge
   logic [7:0] ref_mem [int];
   bit         rd_pend = 0;
   int         rd_exp  = 0;

   always @(negedge clk) begin
      int  ea, raddr;
      bit  acc, off;
      int  x_addr, x_lo, x_hi;
      if (!rst_n) begin
         chk("R7 reset idle", {ram_sel, ext_rd, ext_wr, ext_lo_oe, ext_hi_oe}, 0);
         rd_pend = 0;
      end else begin
         if (rd_pend) chk("R8 read data", rd_data, rd_exp);
         rd_pend = 0;
         ea    = wide_form ? int'(dptr) : int'({page_reg, index_reg});   // R2
         raddr = ea % SIZE;
         acc   = rd_req || wr_req;
         case (mode)
            2'b00:   off = 0;                 // R1
            2'b11:   off = 1;                 // R3
            default: off = (ea >= SIZE);      // R3
         endcase
         x_addr = 0; x_lo = 0; x_hi = 0;
         if (acc && off) begin
            x_lo = 1;
            if (wide_form) begin x_hi = 1; x_addr = ea % 4096; end             // R6
            else if (mode == 2'b01) begin x_hi = 0; x_addr = ea % 256; end   // R4
            else begin x_hi = 1; x_addr = (int'(page_reg % 16) * 256) + (ea % 256); end // R5
         end
         chk("R7 ram_sel", ram_sel, int'(acc && !off));
         chk("R7 ram_we", ram_we, int'(wr_req && !off));
         chk("R7 ext_rd", ext_rd, int'(rd_req && off));
         chk("R7 ext_wr", ext_wr, int'(wr_req && off));
         chk("R6 ext_lo_oe", ext_lo_oe, x_lo);
         chk("R4 ext_hi_oe", ext_hi_oe, x_hi);
         chk("R5 ext_addr", ext_addr, x_addr);
         if (acc && !off) chk("R1 ram_addr wrap", ram_addr, raddr);
         if (wr_req) begin
            chk("R7 ram_wdata", ram_wdata, wr_data);
            chk("R7 ext_wdata", ext_wdata, wr_data);
         end
         if (wr_req && !off) ref_mem[raddr] = wr_data;
         if (rd_req) begin
            rd_pend = 1;
            if (off) rd_exp = int'(ext_pattern(x_addr[11:0]));
            else     rd_exp = ref_mem.exists(raddr) ? int'(ref_mem[raddr]) : 0;
         end
      end
   end

   task automatic acc8(input logic [1:0] m, input logic [7:0] pg, input logic [7:0] ix,
                       input bit rd, input bit wr, input logic [7:0] d);
      @(posedge clk); #1;
      mode = m; wide_form = 0; page_reg = pg; index_reg = ix;
      dptr = 16'hDEAD; rd_req = rd; wr_req = wr; wr_data = d;
   endtask

   task automatic acc16(input logic [1:0] m, input logic [15:0] p,
                        input bit rd, input bit wr, input logic [7:0] d);
      @(posedge clk); #1;
      mode = m; wide_form = 1; dptr = p; page_reg = 8'h5C; index_reg = 8'h3E;
      rd_req = rd; wr_req = wr; wr_data = d;
   endtask

   task automatic idle();
      @(posedge clk); #1;
      rd_req = 0; wr_req = 0;
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : stim
      logic [31:0] lfsr;
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      // R1: wrap in mode 00
      acc16(2'b00, 16'h0FFF, 0, 1, 8'h11);
      acc16(2'b00, 16'h1000, 0, 1, 8'h22);
      acc16(2'b00, 16'h0000, 1, 0, 8'h00);
      acc8 (2'b00, 8'hF7, 8'hFF, 1, 0, 8'h00);
      idle();
      // R3/R4: flat split, page at and below boundary
      acc8 (2'b01, 8'h0F, 8'h80, 0, 1, 8'h33);
      acc8 (2'b01, 8'h10, 8'h80, 0, 1, 8'h44);
      acc8 (2'b01, 8'h3A, 8'h12, 1, 0, 8'h00);
      acc8 (2'b01, 8'h0F, 8'h80, 1, 0, 8'h00);
      // R5: banked split and off-chip-only
      acc8 (2'b10, 8'h3A, 8'h12, 1, 0, 8'h00);
      acc8 (2'b10, 8'h0E, 8'h01, 0, 1, 8'h55);
      acc8 (2'b11, 8'h00, 8'h00, 1, 0, 8'h00);
      acc8 (2'b11, 8'h07, 8'h99, 0, 1, 8'h66);
      // R6: wide form across the boundary
      acc16(2'b01, 16'h0FFF, 1, 0, 8'h00);
      acc16(2'b01, 16'h1000, 1, 0, 8'h00);
      acc16(2'b10, 16'hABCD, 0, 1, 8'h77);
      acc16(2'b11, 16'h0123, 1, 0, 8'h00);
      idle();
      // random mix
      lfsr = 32'h1BADF00D;
      for (int i = 0; i < 2000; i++) begin
         lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
         if (lfsr[3:2] == 2'b00) idle();
         else if (lfsr[4])
            acc16(lfsr[6:5], {lfsr[7] ? 4'h0 : lfsr[11:8], lfsr[23:12]},
                  lfsr[24], !lfsr[24], lfsr[31:24]);
         else
            acc8(lfsr[6:5], {lfsr[7] ? 4'h0 : lfsr[11:8], lfsr[15:12]}, lfsr[23:16],
                 lfsr[24], !lfsr[24], lfsr[31:24]);
      end
      idle();
      idle();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule